// File: doc/BRIEF.md
# Doubleword and Unsigned-Word Memory Access Unit

This unit sits in the execute stage of a 64-bit RISC-V integer pipeline. It handles the three memory instructions that only the 64-bit variant of the ISA adds: the zero-extending word load, the doubleword load and the doubleword store. Each cycle it takes an instruction word with a valid qualifier and the two source register values. It decodes the word and builds the signed 12-bit offset. For loads the offset comes from one contiguous field. For stores it is rebuilt from two separate fields. The unit then forms the byte address and issues a request to a synchronous little-endian data memory with eight byte lanes.

A store drives the complete second operand as write data and enables every lane. A load request returns its read data in the following cycle. In that cycle the unit presents the writeback value with a strobe and the destination index that was captured with the request. A word load picks the half of the read data that address bit 2 points at and fills the upper 32 bits with zeros. A load that names register zero still reads memory but produces no writeback strobe. Accesses that are not naturally aligned are still issued, and a flag is raised alongside them. Any valid word that is none of the three encodings raises an illegal flag instead of a request.

Top module: `rv64_dw_mem_unit`

## Requirements
- R1: A valid word with bits [6:0] = 7'b0000011 and bits [14:12] = 3'b110 (unsigned word load) issues a read request: mem_req=1, mem_we=0, illegal=0.
- R2: A valid word with bits [6:0] = 7'b0000011 and bits [14:12] = 3'b011 (doubleword load) issues a read request: mem_req=1, mem_we=0, illegal=0.
- R3: A valid word with bits [6:0] = 7'b0100011 and bits [14:12] = 3'b011 (doubleword store) issues a write request: mem_req=1, mem_we=1, mem_wdata equal to the full rs2_val, and all eight byte enables set.
- R4: mem_addr equals rs1_val plus a sign-extended 12-bit offset. For loads the offset is instr[31:20]. For the store it is {instr[31:25], instr[11:7]}.
- R5: Byte enables are 8'hFF for the doubleword load and store. For the word load they are 8'h0F when mem_addr[2]=0 and 8'hF0 when mem_addr[2]=1.
- R6: One cycle after a word load request, wb_data equals mem_rdata[31:0] (if the request's address bit 2 was 0) or mem_rdata[63:32] (if it was 1), zero-extended to 64 bits.
- R7: One cycle after a doubleword load request, wb_data equals mem_rdata unchanged.
- R8: wb_valid is high in exactly the cycle after a load request whose destination index instr[11:7] is nonzero, with wb_rd equal to that index. A load with destination 0, a store, an illegal word or an idle cycle gives wb_valid=0 in the next cycle.
- R9: misalign is 1 when a doubleword request has mem_addr[2:0]!=0 or a word request has mem_addr[1:0]!=0, and 0 otherwise. The request is issued either way.
- R10: A valid word that matches none of the three encodings sets illegal=1 and issues no request.
- R11: With instr_valid=0, mem_req, illegal and misalign are 0. After reset, wb_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | Instruction word is valid this cycle |
| instr | input | 32 | Instruction word |
| rs1_val | input | 64 | Base register value |
| rs2_val | input | 64 | Store data register value |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 64 | Byte address of the access |
| mem_be | output | 8 | Byte lane enables, lane i covers bits [8i+7:8i] |
| mem_wdata | output | 64 | Store data |
| mem_rdata | input | 64 | Read data, valid the cycle after a read request |
| wb_valid | output | 1 | Load writeback strobe |
| wb_rd | output | 5 | Writeback destination index |
| wb_data | output | 64 | Writeback value |
| misalign | output | 1 | Current request is not naturally aligned |
| illegal | output | 1 | Valid word is not a supported encoding |

## Verification
Decode, offset assembly and lane selection are combinational. A wrong field, sign bit or lane choice therefore shows on mem_addr, mem_be, mem_req or the flags in the same cycle the word is presented. The only internal state is the captured load context: strobe, destination index, word-or-doubleword flag and lane bit. If any of these is wrong, it shows on wb_valid, wb_rd or wb_data exactly one cycle after the request. That includes a writeback wrongly raised for register zero or a stale half of the read data. Every step of the bench checks that cycle against the request made in the step before it.

// File: rtl/rv64mu_pkg.sv
package rv64mu_pkg;
   typedef enum logic [1:0] {
      MOP_NONE = 2'd0,
      MOP_WORDU = 2'd1,
      MOP_DWLD = 2'd2,
      MOP_DWST = 2'd3
   } mem_op_e;

   localparam logic [6:0] OPC_LOAD  = 7'b0000011;
   localparam logic [6:0] OPC_STORE = 7'b0100011;
   localparam logic [2:0] F3_WORDU  = 3'b110;
   localparam logic [2:0] F3_DWORD  = 3'b011;

   localparam int unsigned OFS_W = 12;
   localparam int unsigned RIDX_W = 5;

   typedef struct packed {
      mem_op_e             op;
      logic [RIDX_W-1:0]   rd;
      logic [OFS_W-1:0]    ofs;
   } dec_s;
endpackage

// File: rtl/rv64mu_decode.sv
module rv64mu_decode
   import rv64mu_pkg::*;
#(
   parameter int unsigned ILEN = 32
) (
   input  logic            instr_valid,
   input  logic [ILEN-1:0] instr,
   output dec_s            dec,
   output logic            illegal
);
   if (ILEN != 32) begin : g_bad_ilen
      $error("rv64mu_decode: ILEN must be 32");
   end

   logic [6:0] opc;
   logic [2:0] f3;

   assign opc = instr[6:0];
   assign f3  = instr[14:12];

   always_comb begin
      dec.op  = MOP_NONE;
      dec.rd  = instr[11:7];
      dec.ofs = instr[31:20];
      if (instr_valid) begin
         if (opc == OPC_LOAD && f3 == F3_WORDU) begin
            dec.op = MOP_WORDU;
         end else if (opc == OPC_LOAD && f3 == F3_DWORD) begin
            dec.op = MOP_DWLD;
         end else if (opc == OPC_STORE && f3 == F3_DWORD) begin
            dec.op  = MOP_DWST;
            dec.ofs = {instr[31:25], instr[11:7]};
         end
      end
   end

   assign illegal = instr_valid && (dec.op == MOP_NONE);

   always_comb begin
      if (!instr_valid) begin
         AST_IDLE_NO_OP: assert (dec.op == MOP_NONE && !illegal); // R11
      end
   end
endmodule

// File: rtl/rv64mu_agen.sv
module rv64mu_agen
   import rv64mu_pkg::*;
#(
   parameter int unsigned XLEN = 64,
   parameter int unsigned IMM_W = 12,
   parameter bit          MISALIGN_CHECK = 1'b1,
   localparam int unsigned NBYTES = XLEN / 8,
   localparam int unsigned WBYTES = 4,
   localparam int unsigned WLANES = NBYTES / WBYTES,
   localparam int unsigned LANE_W = (WLANES > 1) ? $clog2(WLANES) : 1,
   localparam int unsigned DW_LOW = $clog2(NBYTES)
) (
   input  mem_op_e             op,
   input  logic [XLEN-1:0]     base,
   input  logic [IMM_W-1:0]    ofs,
   output logic [XLEN-1:0]     addr,
   output logic [NBYTES-1:0]   be,
   output logic [LANE_W-1:0]   lane_sel,
   output logic                misalign
);
   if (IMM_W >= XLEN) begin : g_bad_imm
      $error("rv64mu_agen: IMM_W must be narrower than XLEN");
   end
   if (WLANES < 2) begin : g_bad_lanes
      $error("rv64mu_agen: XLEN must hold at least two words");
   end

   logic is_dw;
   logic is_w;

   assign addr     = base + {{(XLEN-IMM_W){ofs[IMM_W-1]}}, ofs};
   assign lane_sel = addr[LANE_W+1:2];
   assign is_dw    = (op == MOP_DWLD) || (op == MOP_DWST);
   assign is_w     = (op == MOP_WORDU);

   for (genvar b = 0; b < NBYTES; b++) begin : g_lane
      assign be[b] = is_dw || (is_w && (lane_sel == LANE_W'(b / WBYTES)));
   end

   if (MISALIGN_CHECK) begin : g_mis_on
      assign misalign = (is_dw && (addr[DW_LOW-1:0] != '0))
                     || (is_w && (addr[1:0] != 2'b00));
   end else begin : g_mis_off
      assign misalign = 1'b0;
   end

   always_comb begin
      if (is_w) begin
         AST_WORD_BE_COUNT: assert ($countones(be) == WBYTES); // R5
      end
   end
endmodule

// File: rtl/rv64mu_ldfmt.sv
module rv64mu_ldfmt #(
   parameter int unsigned XLEN = 64,
   localparam int unsigned WLANES = XLEN / 32,
   localparam int unsigned LANE_W = (WLANES > 1) ? $clog2(WLANES) : 1
) (
   input  logic              is_word,
   input  logic [LANE_W-1:0] lane,
   input  logic [XLEN-1:0]   rdata,
   output logic [XLEN-1:0]   data
);
   logic [31:0] word_pick;

   always_comb begin
      word_pick = rdata[lane*32 +: 32];
      data = is_word ? {{(XLEN-32){1'b0}}, word_pick} : rdata;
   end
endmodule

// File: rtl/rv64_dw_mem_unit.sv
module rv64_dw_mem_unit
   import rv64mu_pkg::*;
#(
   parameter int unsigned XLEN = 64,
   parameter int unsigned ILEN = 32,
   parameter bit          MISALIGN_CHECK = 1'b1,
   localparam int unsigned NBYTES = XLEN / 8,
   localparam int unsigned WLANES = NBYTES / 4,
   localparam int unsigned LANE_W = (WLANES > 1) ? $clog2(WLANES) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              instr_valid,
   input  logic [ILEN-1:0]   instr,
   input  logic [XLEN-1:0]   rs1_val,
   input  logic [XLEN-1:0]   rs2_val,
   output logic              mem_req,
   output logic              mem_we,
   output logic [XLEN-1:0]   mem_addr,
   output logic [NBYTES-1:0] mem_be,
   output logic [XLEN-1:0]   mem_wdata,
   input  logic [XLEN-1:0]   mem_rdata,
   output logic              wb_valid,
   output logic [RIDX_W-1:0] wb_rd,
   output logic [XLEN-1:0]   wb_data,
   output logic              misalign,
   output logic              illegal
);
   if (XLEN != 64) begin : g_bad_xlen
      $error("rv64_dw_mem_unit: XLEN must be 64");
   end

   dec_s              dec;
   logic [LANE_W-1:0] lane_sel;
   logic              is_load;
   logic              wb_v_q;
   logic [RIDX_W-1:0] rd_q;
   logic              word_q;
   logic [LANE_W-1:0] lane_q;

   rv64mu_decode #(.ILEN(ILEN)) u_dec (
      .instr_valid (instr_valid),
      .instr       (instr),
      .dec         (dec),
      .illegal     (illegal)
   );

   rv64mu_agen #(
      .XLEN           (XLEN),
      .IMM_W          (OFS_W),
      .MISALIGN_CHECK (MISALIGN_CHECK)
   ) u_agen (
      .op       (dec.op),
      .base     (rs1_val),
      .ofs      (dec.ofs),
      .addr     (mem_addr),
      .be       (mem_be),
      .lane_sel (lane_sel),
      .misalign (misalign)
   );

   assign mem_req   = (dec.op != MOP_NONE);
   assign mem_we    = (dec.op == MOP_DWST);
   assign mem_wdata = rs2_val;
   assign is_load   = (dec.op == MOP_WORDU) || (dec.op == MOP_DWLD);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wb_v_q <= 1'b0;
         rd_q   <= '0;
         word_q <= 1'b0;
         lane_q <= '0;
      end else begin
         wb_v_q <= is_load && (dec.rd != '0);
         if (is_load) begin
            rd_q   <= dec.rd;
            word_q <= (dec.op == MOP_WORDU);
            lane_q <= lane_sel;
         end
      end
   end

   rv64mu_ldfmt #(.XLEN(XLEN)) u_fmt (
      .is_word (word_q),
      .lane    (lane_q),
      .rdata   (mem_rdata),
      .data    (wb_data)
   );

   assign wb_valid = wb_v_q;
   assign wb_rd    = rd_q;

   AST_REQ_XOR_ILLEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      instr_valid |-> (mem_req ^ illegal)); // R10
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !instr_valid |-> (!mem_req && !illegal && !misalign)); // R11
   AST_STORE_ALL_LANES: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we) |-> (mem_be == '1)); // R3
   AST_MISALIGN_ISSUED: assert property (@(posedge clk) disable iff (!rst_n)
      misalign |-> mem_req); // R9
   AST_WB_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
      wb_valid |-> $past(mem_req && !mem_we)); // R8
   AST_WB_RD_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      wb_valid |-> (wb_rd != '0)); // R8
   AST_WB_RD_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
      wb_valid |-> (wb_rd == $past(instr[11:7]))); // R8
   AST_BE_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> ($countones(mem_be) == NBYTES || $countones(mem_be) == 4)); // R5
endmodule

// File: tb/rv64_dw_mem_unit_tb.sv
module rv64_dw_mem_unit_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        instr_valid = 1'b0;
   logic [31:0] instr = '0;
   logic [63:0] rs1_val = '0;
   logic [63:0] rs2_val = '0;
   logic [63:0] mem_rdata = '0;
   logic        mem_req, mem_we, wb_valid, misalign, illegal;
   logic [63:0] mem_addr, mem_wdata, wb_data;
   logic [7:0]  mem_be;
   logic [4:0]  wb_rd;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   bit          pend_v = 1'b0;
   bit          pend_word = 1'b0;
   bit          pend_hi = 1'b0;
   logic [4:0]  pend_rd = '0;

   always #2 clk = ~clk;

   rv64_dw_mem_unit dut_i (
      .clk (clk), .rst_n (rst_n), .instr_valid (instr_valid), .instr (instr),
      .rs1_val (rs1_val), .rs2_val (rs2_val), .mem_req (mem_req), .mem_we (mem_we),
      .mem_addr (mem_addr), .mem_be (mem_be), .mem_wdata (mem_wdata),
      .mem_rdata (mem_rdata), .wb_valid (wb_valid), .wb_rd (wb_rd),
      .wb_data (wb_data), .misalign (misalign), .illegal (illegal)
   );

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] mk_load(input logic [2:0] f3, input logic [4:0] rd,
                                           input logic [11:0] ofs);
      return {ofs, 5'd1, f3, rd, 7'b0000011};
   endfunction

   function automatic logic [31:0] mk_store(input logic [11:0] ofs);
      return {ofs[11:5], 5'd2, 5'd1, 3'b011, ofs[4:0], 7'b0100011};
   endfunction

   // 0 idle, 1 word load, 2 dword load, 3 dword store, 4 illegal
   function automatic int classify(input logic v, input logic [31:0] w);
      if (!v) return 0;
      if (w[6:0] == 7'b0000011 && w[14:12] == 3'b110) return 1;
      if (w[6:0] == 7'b0000011 && w[14:12] == 3'b011) return 2;
      if (w[6:0] == 7'b0100011 && w[14:12] == 3'b011) return 3;
      return 4;
   endfunction

   function automatic logic [63:0] exp_addr(input int k, input logic [31:0] w,
                                            input logic [63:0] base);
      logic [11:0] o;
      o = (k == 3) ? {w[31:25], w[11:7]} : w[31:20];
      return base + {{52{o[11]}}, o};
   endfunction

   task automatic step(input logic v, input logic [31:0] w, input logic [63:0] a,
                       input logic [63:0] b, input logic [63:0] rd_data);
      int k;
      logic [63:0] ea;
      logic [63:0] exp_wb;
      @(negedge clk);
      instr_valid = v; instr = w; rs1_val = a; rs2_val = b; mem_rdata = rd_data;
      #1;
      chk("R8 wb_valid", {63'd0, wb_valid}, {63'd0, pend_v});
      if (pend_v) begin
         chk("R8 wb_rd", {59'd0, wb_rd}, {59'd0, pend_rd});
         if (pend_word) begin
            exp_wb = {32'd0, pend_hi ? rd_data[63:32] : rd_data[31:0]};
            chk("R6 word writeback", wb_data, exp_wb);
         end else begin
            chk("R7 dword writeback", wb_data, rd_data);
         end
      end
      k = classify(v, w);
      ea = exp_addr(k, w, a);
      case (k)
         0: begin
            chk("R11 idle req", {61'd0, mem_req, illegal, misalign}, 64'd0);
         end
         4: begin
            chk("R10 illegal", {62'd0, mem_req, illegal}, 64'd1);
         end
         default: begin
            chk(k == 1 ? "R1 word load req" : (k == 2 ? "R2 dword load req" : "R3 store req"),
                {61'd0, mem_req, mem_we, illegal}, {61'd0, 1'b1, k == 3, 1'b0});
            chk("R4 address", mem_addr, ea);
            chk("R5 byte enables", {56'd0, mem_be},
                {56'd0, (k == 1) ? (ea[2] ? 8'hF0 : 8'h0F) : 8'hFF});
            chk("R9 misalign", {63'd0, misalign},
                {63'd0, (k == 1) ? (ea[1:0] != 0) : (ea[2:0] != 0)});
            if (k == 3) chk("R3 store data", mem_wdata, b);
         end
      endcase
      pend_v    = (k == 1 || k == 2) && (w[11:7] != 5'd0);
      pend_word = (k == 1);
      pend_hi   = ea[2];
      pend_rd   = w[11:7];
   endtask

   function automatic logic [63:0] r64();
      return {$urandom(), $urandom()};
   endfunction

   initial begin
      void'($urandom(32'h5EED_1234));
      repeat (3) @(negedge clk);
      #1;
      chk("R11 reset wb_valid", {63'd0, wb_valid}, 64'd0);
      rst_n = 1'b1;
      // directed corners
      step(1, mk_load(3'b110, 5'd5, 12'h004), 64'h1000, 0, r64());           // R6 upper half
      step(1, mk_load(3'b110, 5'd6, 12'h000), 64'h2000, 0, r64());           // R6 lower half
      step(1, mk_load(3'b011, 5'd0, 12'h008), 64'h3000, 0, r64());           // R8 rd zero
      step(1, mk_load(3'b011, 5'd7, 12'hFF8), 64'h4000, 0, r64());           // R4 negative offset
      step(1, mk_store(12'h80F), 64'h10000, 64'hDEAD_BEEF_0123_4567, r64()); // R3, R9 split offset
      step(1, mk_load(3'b010, 5'd3, 12'h000), 64'h5000, 0, r64());           // R10 word signed load
      step(1, {7'd0, 5'd2, 5'd1, 3'b010, 5'd0, 7'b0100011}, 64'h0, 0, r64()); // R10 word store
      step(1, mk_load(3'b110, 5'd9, 12'h002), 64'h6000, 0, r64());           // R9 word misalign
      step(0, mk_load(3'b011, 5'd4, 12'h0), 64'h0, 0, r64());                // R11 idle
      step(1, mk_load(3'b011, 5'd31, 12'h7FF), 64'hFFFF_FFFF_FFFF_F801, 0, r64()); // R2 wrap
      // constrained random
      for (int i = 0; i < 600; i++) begin
         int sel;
         logic [31:0] w;
         logic [63:0] a;
         logic [11:0] o;
         sel = $urandom_range(0, 9);
         o = 12'($urandom());
         a = r64();
         if ($urandom_range(0, 2) == 0) a[2:0] = 3'b000;
         if ($urandom_range(0, 2) == 0) o[2:0] = 3'b000;
         case (sel)
            0, 1: w = mk_load(3'b110, 5'($urandom_range(0, 31)), o);
            2, 3: w = mk_load(3'b011, 5'($urandom_range(0, 31)), o);
            4, 5: w = mk_store(o);
            6, 7: w = $urandom();
            default: w = mk_load(3'b011, 5'($urandom_range(1, 31)), o);
         endcase
         step(sel != 9 || ($urandom_range(0, 1) == 0), w, a, r64(), r64());
      end
      step(0, 32'd0, 0, 0, r64());
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #400000;
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule